// File: doc/BRIEF.md
# Loop-and-Call Register Sequencer

This block is a very small programmable controller meant to sit inside custom logic in place of a hand-coded control state machine. It walks through a byte-wide program held in an external on-chip memory with one cycle of read latency. It uses that program to drive a bank of up to sixteen peripheral registers over a plain strobe bus. Its only computation is counting down: a loop counter is tested, decremented and used to branch. Apart from that it can jump, call and return, push constants and move bytes to and from registers.

A single eight-entry hardware stack holds return addresses and loop counters together. A subroutine can therefore run inside a counted loop without disturbing the count beneath its return address. A value read from a register is pushed onto the same stack, so the peripherals themselves can supply loop counts. The core waits idle after reset. A start pulse runs the program from address 0. It stops on a halt instruction, which raises `done`, or on a stack fault, which raises `err`.

Top module: `seq_core`

## Requirements
- R1: A synchronous reset leaves `done` and `err` low, both strobes low and `pm_addr` at 0, and the core fetches nothing until `start` is seen.
- R2: A `start` pulse, in any state, empties the stack and clears `done` and `err`. On the next cycle `pm_addr` is 0, and execution proceeds from there.
- R3: The opcode sits in bits 7:5 of the first byte: 000 halt, 001 call, 010 jump, 011 loop, 100 push, 101 return, 110 write, 111 read. Call, jump, loop, push and write take a second operand byte. A one-byte instruction takes 2 cycles and a two-byte instruction takes 4 cycles.
- R4: Halt stops fetching. `done` rises at the clock edge that ends the halt's second cycle and stays high until the next `start`. While halted, `pm_addr` holds still and no strobe is raised.
- R5: Jump continues execution at the address given by its operand byte.
- R6: Loop looks at the top of stack. If it is 0, the entry is popped and execution falls through. Otherwise the entry is decremented and execution branches to the operand address. A program of the form push N, jump to the loop, body, loop runs the body exactly N times, for N from 0 to 255.
- R7: Call pushes the address that follows its operand byte and branches to the operand. Return pops the top of stack into the program counter. A loop counter lying below a return address is preserved.
- R8: Write raises `reg_we` for one cycle, with `reg_addr` taken from bits 3:0 of the first byte and `reg_wdata` taken from the operand byte.
- R9: Read raises `reg_re` for one cycle, with `reg_addr` taken from bits 3:0 of the instruction. It pushes `reg_rdata` from that same cycle onto the stack.
- R10: A push, call or read issued while the stack already holds 8 entries sets `err`, stops the core and raises no strobe. `err` stays set until `start`.
- R11: A return or loop issued with an empty stack sets `err` and stops the core. `done` and `err` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle pulse that runs the program from address 0 |
| pm_addr | output | 8 | Program memory read address |
| pm_rdata | input | 8 | Program memory data, one cycle after the address |
| reg_addr | output | 4 | Peripheral register address |
| reg_wdata | output | 8 | Peripheral register write data |
| reg_we | output | 1 | Write strobe, one cycle |
| reg_re | output | 1 | Read strobe, one cycle |
| reg_rdata | input | 8 | Peripheral register read data, sampled while `reg_re` is high |
| done | output | 1 | Halt reached |
| err | output | 1 | Sticky stack overflow or underflow fault |

## Verification
Let E0 be the clock edge that samples `start`. The halt's `done` flag is due exactly two edges after the sum of the instruction costs that precede it (2 or 4 each). A fault's `err` flag is due at the edge that ends the faulting instruction. The bench works out these edge counts from the program it loads. It counts the edges after E0 and samples the flags half a period after each edge, so a single-cycle shift in any path is a mismatch. The strobes are combinational from the state register. They are therefore checked at the falling edge inside the cycle in which they are raised, against the expected address and data.

// File: rtl/seq_pkg.sv
package seq_pkg;

    // Opcode field, bits [7:5] of the first instruction byte.
    typedef enum logic [2:0] {
        OP_HALT  = 3'd0,
        OP_CALL  = 3'd1,
        OP_JUMP  = 3'd2,
        OP_LOOP  = 3'd3,
        OP_PUSH  = 3'd4,
        OP_RET   = 3'd5,
        OP_WRITE = 3'd6,
        OP_READ  = 3'd7
    } op_e;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_FETCH   = 3'd1,
        ST_DECODE  = 3'd2,
        ST_OPFETCH = 3'd3,
        ST_EXEC    = 3'd4
    } st_e;

    localparam int OP_W = 3;

endpackage

// File: rtl/seq_decode.sv
module seq_decode
    import seq_pkg::*;
#(
    parameter int DW   = 8,
    parameter int RA_W = 4
) (
    input  logic [DW-1:0]   ins,
    output op_e             op,
    output logic            two_byte,
    output logic [RA_W-1:0] raddr
);

    always_comb begin
        op    = op_e'(ins[DW-1 -: OP_W]);
        raddr = ins[RA_W-1:0];
        case (op)
            OP_CALL, OP_JUMP, OP_LOOP, OP_PUSH, OP_WRITE: two_byte = 1'b1;
            default:                                      two_byte = 1'b0;
        endcase
    end

endmodule

// File: rtl/seq_stack.sv
module seq_stack #(
    parameter int W     = 8,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clear,
    input  logic         push,
    input  logic         pop,
    input  logic         set_top,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] top,
    output logic         full,
    output logic         empty
);

    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int SP_W  = $clog2(DEPTH + 1);

    logic [W-1:0]     mem_q [DEPTH];
    logic [W-1:0]     mem_d [DEPTH];
    logic [SP_W-1:0]  sp_q, sp_d;
    logic [IDX_W-1:0] wr_idx, top_idx;

    assign wr_idx  = IDX_W'(sp_q);
    assign top_idx = IDX_W'(sp_q - SP_W'(1));
    assign empty   = (sp_q == '0);
    assign full    = (sp_q == SP_W'(DEPTH));
    assign top     = empty ? '0 : mem_q[top_idx];

    always_comb begin
        mem_d = mem_q;
        sp_d  = sp_q;
        if (clear) begin
            sp_d = '0;
        end else if (push) begin
            mem_d[wr_idx] = wdata;
            sp_d          = sp_q + SP_W'(1);
        end else if (pop) begin
            sp_d = sp_q - SP_W'(1);
        end else if (set_top) begin
            mem_d[top_idx] = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sp_q <= '0;
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else begin
            sp_q  <= sp_d;
            mem_q <= mem_d;
        end
    end

endmodule

// File: rtl/seq_core.sv
module seq_core
    import seq_pkg::*;
#(
    parameter int PC_W        = 8,
    parameter int DW          = 8,
    parameter int RA_W        = 4,
    parameter int STACK_DEPTH = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    output logic [PC_W-1:0] pm_addr,
    input  logic [DW-1:0]   pm_rdata,
    output logic [RA_W-1:0] reg_addr,
    output logic [DW-1:0]   reg_wdata,
    output logic            reg_we,
    output logic            reg_re,
    input  logic [DW-1:0]   reg_rdata,
    output logic            done,
    output logic            err
);

    localparam int SW = (PC_W > DW) ? PC_W : DW;

    typedef struct packed {
        st_e             st;
        logic [PC_W-1:0] pc;
        op_e             op;
        logic [RA_W-1:0] ra;
        logic            done;
        logic            err;
    } core_t;

    core_t q, n;

    op_e             dec_op;
    logic            dec_two;
    logic [RA_W-1:0] dec_ra;

    logic          stk_clear, stk_push, stk_pop, stk_set;
    logic [SW-1:0] stk_wdata, stk_top;
    logic          stk_full, stk_empty;

    logic [PC_W-1:0] pc_inc;
    assign pc_inc = q.pc + PC_W'(1);

    seq_decode #(.DW(DW), .RA_W(RA_W)) u_dec (
        .ins      (pm_rdata),
        .op       (dec_op),
        .two_byte (dec_two),
        .raddr    (dec_ra)
    );

    seq_stack #(.W(SW), .DEPTH(STACK_DEPTH)) u_stk (
        .clk     (clk),
        .rst     (rst),
        .clear   (stk_clear),
        .push    (stk_push),
        .pop     (stk_pop),
        .set_top (stk_set),
        .wdata   (stk_wdata),
        .top     (stk_top),
        .full    (stk_full),
        .empty   (stk_empty)
    );

    always_comb begin
        n         = q;
        stk_clear = 1'b0;
        stk_push  = 1'b0;
        stk_pop   = 1'b0;
        stk_set   = 1'b0;
        stk_wdata = '0;
        reg_we    = 1'b0;
        reg_re    = 1'b0;
        reg_addr  = '0;
        reg_wdata = '0;

        case (q.st)
            ST_FETCH: n.st = ST_DECODE;

            ST_DECODE: begin
                n.op = dec_op;
                n.ra = dec_ra;
                if (dec_two) begin
                    n.pc = pc_inc;
                    n.st = ST_OPFETCH;
                end else begin
                    case (dec_op)
                        OP_RET: begin
                            if (stk_empty) begin
                                n.err = 1'b1;
                                n.st  = ST_IDLE;
                            end else begin
                                stk_pop = 1'b1;
                                n.pc    = PC_W'(stk_top);
                                n.st    = ST_FETCH;
                            end
                        end
                        OP_READ: begin
                            if (stk_full) begin
                                n.err = 1'b1;
                                n.st  = ST_IDLE;
                            end else begin
                                reg_re    = 1'b1;
                                reg_addr  = dec_ra;
                                stk_push  = 1'b1;
                                stk_wdata = SW'(reg_rdata);
                                n.pc      = pc_inc;
                                n.st      = ST_FETCH;
                            end
                        end
                        default: begin
                            n.done = 1'b1;
                            n.st   = ST_IDLE;
                        end
                    endcase
                end
            end

            ST_OPFETCH: n.st = ST_EXEC;

            ST_EXEC: begin
                n.pc = pc_inc;
                n.st = ST_FETCH;
                case (q.op)
                    OP_CALL: begin
                        if (stk_full) begin
                            n.err = 1'b1;
                            n.st  = ST_IDLE;
                        end else begin
                            stk_push  = 1'b1;
                            stk_wdata = SW'(pc_inc);
                            n.pc      = PC_W'(pm_rdata);
                        end
                    end
                    OP_JUMP: n.pc = PC_W'(pm_rdata);
                    OP_LOOP: begin
                        if (stk_empty) begin
                            n.err = 1'b1;
                            n.st  = ST_IDLE;
                        end else if (stk_top == '0) begin
                            stk_pop = 1'b1;
                        end else begin
                            stk_set   = 1'b1;
                            stk_wdata = stk_top - SW'(1);
                            n.pc      = PC_W'(pm_rdata);
                        end
                    end
                    OP_PUSH: begin
                        if (stk_full) begin
                            n.err = 1'b1;
                            n.st  = ST_IDLE;
                        end else begin
                            stk_push  = 1'b1;
                            stk_wdata = SW'(pm_rdata);
                        end
                    end
                    OP_WRITE: begin
                        reg_we    = 1'b1;
                        reg_addr  = q.ra;
                        reg_wdata = pm_rdata;
                    end
                    default: ;
                endcase
            end

            default: ;
        endcase

        if (start) begin
            n.st      = ST_FETCH;
            n.pc      = '0;
            n.done    = 1'b0;
            n.err     = 1'b0;
            stk_clear = 1'b1;
            reg_we    = 1'b0;
            reg_re    = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q.st   <= ST_IDLE;
            q.pc   <= '0;
            q.op   <= OP_HALT;
            q.ra   <= '0;
            q.done <= 1'b0;
            q.err  <= 1'b0;
        end else begin
            q <= n;
        end
    end

    assign pm_addr = q.pc;
    assign done    = q.done;
    assign err     = q.err;

endmodule

// File: rtl/seq_core_chk.sv
module seq_core_chk #(
    parameter int PC_W = 8,
    parameter int DW   = 8,
    parameter int RA_W = 4
) (
    input logic            clk,
    input logic            rst,
    input logic            start,
    input logic [PC_W-1:0] pm_addr,
    input logic [RA_W-1:0] reg_addr,
    input logic [DW-1:0]   reg_wdata,
    input logic            reg_we,
    input logic            reg_re,
    input logic            done,
    input logic            err
);

    p_reset_idle_r1: assert property (@(posedge clk)
        rst |=> (!done && !err && !reg_we && !reg_re && pm_addr == '0));

    p_start_restart_r2: assert property (@(posedge clk) disable iff (rst)
        start |=> (!done && !err && pm_addr == '0));

    p_done_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> done);

    p_halt_quiet_r4: assert property (@(posedge clk) disable iff (rst)
        (done || err) |-> (!reg_we && !reg_re));

    p_halt_pc_r4: assert property (@(posedge clk) disable iff (rst)
        ((done || err) && !start) |=> $stable(pm_addr));

    p_we_single_r8: assert property (@(posedge clk) disable iff (rst)
        reg_we |=> !reg_we);

    p_re_single_r9: assert property (@(posedge clk) disable iff (rst)
        reg_re |=> !reg_re);

    p_strobe_excl_r8: assert property (@(posedge clk) disable iff (rst)
        !(reg_we && reg_re));

    p_err_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        (err && !start) |=> err);

    p_no_both_r11: assert property (@(posedge clk) disable iff (rst)
        !(done && err));

endmodule

bind seq_core seq_core_chk #(.PC_W(PC_W), .DW(DW), .RA_W(RA_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .pm_addr   (pm_addr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_we    (reg_we),
    .reg_re    (reg_re),
    .done      (done),
    .err       (err)
);

// File: tb/test_seq_core.sv
`timescale 1ns/1ps
module test_seq_core;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic [7:0] pm_addr;
    logic [7:0] pm_rdata = 8'h00;
    logic [3:0] reg_addr;
    logic [7:0] reg_wdata;
    logic       reg_we, reg_re;
    logic [7:0] reg_rdata;
    logic       done, err;

    logic [7:0] prog [256];

    int n_cmp = 0;
    int n_bad = 0;
    int wr_cnt = 0, wr_bad = 0, re_cnt = 0, re_bad = 0;
    logic [3:0] exp_wa = 4'h0, exp_ra = 4'h0;
    logic [7:0] exp_wd = 8'h00;

    always #5 clk = ~clk;

    seq_core i_seq_core (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .pm_addr   (pm_addr),
        .pm_rdata  (pm_rdata),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_we    (reg_we),
        .reg_re    (reg_re),
        .reg_rdata (reg_rdata),
        .done      (done),
        .err       (err)
    );

    // Program memory with one cycle of read latency; registers return their own address.
    always @(posedge clk) pm_rdata <= prog[pm_addr];
    assign reg_rdata = {4'h0, reg_addr};

    always @(negedge clk) begin
        if (reg_we) begin
            wr_cnt++;
            if (reg_addr !== exp_wa || reg_wdata !== exp_wd) wr_bad++;
        end
        if (reg_re) begin
            re_cnt++;
            if (reg_addr !== exp_ra) re_bad++;
        end
    end

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not finish, act=hung exp=finished");
        summary();
        $finish;
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic clear_prog();
        for (int i = 0; i < 256; i++) prog[i] = 8'h00;
    endtask

    // Pulse start, then count edges after the sampling edge until done or err.
    task automatic run_prog(output int cyc);
        @(negedge clk);
        wr_cnt = 0; wr_bad = 0; re_cnt = 0; re_bad = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        while (!(done || err) && cyc < 3000) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    task automatic load_loop(input int cnt);
        clear_prog();
        prog[0] = 8'h80; prog[1] = 8'(cnt);
        prog[2] = 8'h40; prog[3] = 8'd6;
        prog[4] = 8'hC3; prog[5] = 8'hA5;
        prog[6] = 8'h60; prog[7] = 8'd4;
        prog[8] = 8'h00;
        exp_wa = 4'h3; exp_wd = 8'hA5;
    endtask

    initial begin
        int cyc;
        int cnt;
        int snap;
        logic [7:0] pa;
        clear_prog();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state and idling without start
        chk("R1 done after reset", int'(done), 0);
        chk("R1 err after reset", int'(err), 0);
        chk("R1 pm_addr after reset", int'(pm_addr), 0);
        chk("R1 strobes after reset", int'(reg_we | reg_re), 0);
        repeat (6) @(negedge clk);
        chk("R1 idle pm_addr", int'(pm_addr), 0);
        chk("R1 idle done", int'(done), 0);

        // R6 / R3 / R8: counted loop sweep, including zero and 255
        for (int k = 0; k <= 13; k++) begin
            cnt = (k == 13) ? 255 : k;
            load_loop(cnt);
            run_prog(cyc);
            chk($sformatf("R3 R6 loop n=%0d cycles", cnt), cyc, 14 + 8 * cnt);
            chk($sformatf("R6 loop n=%0d writes", cnt), wr_cnt, cnt);
            chk($sformatf("R8 loop n=%0d write fields", cnt), wr_bad, 0);
            chk($sformatf("R4 loop n=%0d done", cnt), int'(done), 1);
            chk($sformatf("R11 loop n=%0d err", cnt), int'(err), 0);
        end

        // R4: halted core stays quiet and holds its address
        pa = pm_addr;
        snap = wr_cnt;
        repeat (20) @(negedge clk);
        chk("R4 halted pm_addr stable", int'(pm_addr), int'(pa));
        chk("R4 halted no writes", wr_cnt, snap);
        chk("R4 done held", int'(done), 1);

        // R7: subroutine inside a counted loop
        for (int k = 0; k <= 6; k++) begin
            clear_prog();
            prog[0] = 8'h80; prog[1] = 8'(k);
            prog[2] = 8'h40; prog[3] = 8'd6;
            prog[4] = 8'h20; prog[5] = 8'd10;
            prog[6] = 8'h60; prog[7] = 8'd4;
            prog[8] = 8'h00;
            prog[10] = 8'hC5; prog[11] = 8'h3C;
            prog[12] = 8'hA0;
            exp_wa = 4'h5; exp_wd = 8'h3C;
            run_prog(cyc);
            chk($sformatf("R7 call n=%0d cycles", k), cyc, 14 + 14 * k);
            chk($sformatf("R7 call n=%0d writes", k), wr_cnt, k);
            chk($sformatf("R7 call n=%0d fields", k), wr_bad, 0);
            chk($sformatf("R7 call n=%0d err", k), int'(err), 0);
        end

        // R9: loop count taken from a register read, every address
        for (int a = 0; a < 16; a++) begin
            clear_prog();
            prog[0] = 8'hE0 | 8'(a);
            prog[1] = 8'h40; prog[2] = 8'd5;
            prog[3] = 8'hC0; prog[4] = 8'h11;
            prog[5] = 8'h60; prog[6] = 8'd3;
            prog[7] = 8'h00;
            exp_wa = 4'h0; exp_wd = 8'h11; exp_ra = 4'(a);
            run_prog(cyc);
            chk($sformatf("R9 read a=%0d cycles", a), cyc, 12 + 8 * a);
            chk($sformatf("R9 read a=%0d strobes", a), re_cnt, 1);
            chk($sformatf("R9 read a=%0d address", a), re_bad, 0);
            chk($sformatf("R9 read a=%0d writes", a), wr_cnt, a);
        end

        // R5: forward jump skips a write
        clear_prog();
        prog[0] = 8'h40; prog[1] = 8'd6;
        prog[2] = 8'hC1; prog[3] = 8'h11;
        prog[4] = 8'h00;
        prog[6] = 8'hC2; prog[7] = 8'h22;
        prog[8] = 8'h00;
        exp_wa = 4'h2; exp_wd = 8'h22;
        run_prog(cyc);
        chk("R5 jump cycles", cyc, 10);
        chk("R5 jump writes", wr_cnt, 1);
        chk("R5 jump target fields", wr_bad, 0);

        // R10: push depth sweep, ninth push faults
        for (int k = 1; k <= 9; k++) begin
            clear_prog();
            for (int i = 0; i < k; i++) begin
                prog[2*i] = 8'h80; prog[2*i+1] = 8'(i + 1);
            end
            prog[2*k] = 8'hC2; prog[2*k+1] = 8'h77;
            prog[2*k+2] = 8'h00;
            exp_wa = 4'h2; exp_wd = 8'h77;
            run_prog(cyc);
            if (k <= 8) begin
                chk($sformatf("R10 depth %0d cycles", k), cyc, 4 * k + 6);
                chk($sformatf("R10 depth %0d err", k), int'(err), 0);
                chk($sformatf("R10 depth %0d writes", k), wr_cnt, 1);
            end else begin
                chk("R10 overflow cycle", cyc, 36);
                chk("R10 overflow err", int'(err), 1);
                chk("R11 overflow done low", int'(done), 0);
                repeat (20) @(negedge clk);
                chk("R10 overflow no write", wr_cnt, 0);
                chk("R10 err sticky", int'(err), 1);
            end
        end

        // R10: read onto a full stack faults without a strobe
        clear_prog();
        for (int i = 0; i < 8; i++) begin
            prog[2*i] = 8'h80; prog[2*i+1] = 8'h01;
        end
        prog[16] = 8'hE3; prog[17] = 8'hC2; prog[18] = 8'h77;
        run_prog(cyc);
        chk("R10 read overflow cycle", cyc, 34);
        chk("R10 read overflow err", int'(err), 1);
        chk("R10 read overflow no strobe", re_cnt, 0);

        // R11: return and loop on an empty stack
        clear_prog();
        prog[0] = 8'hA0; prog[1] = 8'hC2; prog[2] = 8'h77; prog[3] = 8'h00;
        run_prog(cyc);
        chk("R11 return underflow cycle", cyc, 2);
        chk("R11 return underflow err", int'(err), 1);
        chk("R11 return underflow writes", wr_cnt, 0);
        clear_prog();
        prog[0] = 8'h60; prog[1] = 8'h00; prog[2] = 8'hC2; prog[3] = 8'h77;
        run_prog(cyc);
        chk("R11 loop underflow cycle", cyc, 4);
        chk("R11 loop underflow err", int'(err), 1);
        chk("R11 loop underflow done", int'(done), 0);

        // R2: start after a fault clears err and runs cleanly
        load_loop(2);
        run_prog(cyc);
        chk("R2 err cleared by start", int'(err), 0);
        chk("R2 rerun cycles", cyc, 30);

        // R2: restart in the middle of a long loop
        load_loop(200);
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (50) @(negedge clk);
        start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk("R2 restart pm_addr", int'(pm_addr), 0);
        chk("R2 restart done low", int'(done), 0);
        cyc = 0;
        while (!(done || err) && cyc < 3000) begin
            @(negedge clk);
            cyc++;
        end
        chk("R2 restart cycles", cyc, 14 + 8 * 200);

        summary();
        $finish;
    end

endmodule